// File: doc/BRIEF.md
# Coherent Time Snapshot Read Latch

This block sits between a processor-style register read port and a bank of free-running timekeeping counters. A multi-field time value read one byte at a time can tear when a carry ripples through the counters between two reads. To prevent this, a read of the hundredths-of-second location (address 00h) does two things: it returns the live hundredths value, and on the same clock edge it copies the other seven time fields into holding registers. Later reads of addresses 01h to 07h return that frozen copy. Software reads 00h first and then collects a consistent set of fields at its own pace.

The trigger is a two-state machine. TRG_OPEN means no hundredths read is in progress. On the first sampled strobe to 00h it emits a one-cycle capture pulse and moves to TRG_SEEN. It stays in TRG_SEEN while the strobe remains on 00h. It returns to TRG_OPEN (transition "release") as soon as the strobe drops or the address leaves 00h. The transition "arm" (TRG_OPEN to TRG_SEEN) is the only one that captures.

Addresses with any bit above bit 2 set belong to general-purpose RAM. Their data comes in on a separate input and is passed through without being held. Read data is registered.

Top module: `snap_read_latch`

## Requirements
- R1: Time fields are decoded from rd_addr[2:0] when all higher address bits are zero: 0 hundredths, 1 hours, 2 minutes, 3 seconds, 4 month, 5 date, 6 year, 7 day of week.
- R2: A read of address 00h returns the hundredths input value present in the cycle the strobe is sampled. That value is never taken from a holding register.
- R3: On the edge where a read of 00h is sampled, all seven other counter inputs are copied into holding registers.
- R4: Reads of addresses 01h to 07h return the held copy. The held copy does not change when the counters change, until the next capturing read of 00h.
- R5: A strobe held on 00h over several consecutive cycles captures only on its first cycle. A new capture needs a cycle in which the strobe is low or the address is not 00h.
- R6: During and after reset, before any capture, rd_data and every held field read as zero.
- R7: Any address with a bit above bit 2 set returns ram_rdata as sampled in the strobe cycle. Such reads never alter the held fields.
- R8: rd_data updates one cycle after a sampled strobe and keeps its value in cycles without a strobe.
- R9: When the counters change on the same edge as a capture, the held copy contains the values presented in the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_addr | input | ADDR_W | Read address |
| cnt_hund | input | DATA_W | Live hundredths counter |
| cnt_hour | input | DATA_W | Live hours counter |
| cnt_min | input | DATA_W | Live minutes counter |
| cnt_sec | input | DATA_W | Live seconds counter |
| cnt_month | input | DATA_W | Live month counter |
| cnt_date | input | DATA_W | Live date counter |
| cnt_year | input | DATA_W | Live year counter |
| cnt_wday | input | DATA_W | Live day-of-week counter |
| ram_rdata | input | DATA_W | Data from general-purpose RAM for addresses above 07h |
| rd_data | output | DATA_W | Registered read data |

## Verification
Two things can land on one clock edge: a capture triggered by a 00h read, and a change of the counter inputs that the capture copies. The bench provokes this by stepping every counter on every cycle while it issues 00h reads, both single and held. It then reads back 01h to 07h and judges the result against a behavioural model that snapshots exactly the values presented in the capture cycle. A held 00h strobe over changing counters also shows whether a second capture happens in the TRG_SEEN state.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef enum logic [SLOT_W-1:0] {
        SLOT_HUND  = 3'd0,
        SLOT_HOUR  = 3'd1,
        SLOT_MIN   = 3'd2,
        SLOT_SEC   = 3'd3,
        SLOT_MONTH = 3'd4,
        SLOT_DATE  = 3'd5,
        SLOT_YEAR  = 3'd6,
        SLOT_WDAY  = 3'd7
    } time_slot_e;

    typedef enum logic {
        TRG_OPEN = 1'b0,
        TRG_SEEN = 1'b1
    } trg_state_e;
endpackage

// File: rtl/snap_trigger.sv
module snap_trigger
    import snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hund_hit,
    output logic cap_pulse
);
    trg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRG_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cap_pulse = 1'b0;
        unique case (state_q)
            TRG_OPEN: begin
                if (hund_hit) begin
                    cap_pulse = 1'b1;
                    state_d   = TRG_SEEN;
                end
            end
            TRG_SEEN: begin
                if (!hund_hit) state_d = TRG_OPEN;
            end
            default: state_d = TRG_OPEN;
        endcase
    end
endmodule

// File: rtl/snap_hold.sv
module snap_hold
    import snap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_pulse,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  live_vec,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  held_vec
);
    // Slot 0 (hundredths) is never held.
    assign held_vec[SLOT_HUND] = '0;

    for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_slot
        logic [DATA_W-1:0] field_q;
        always_ff @(posedge clk) begin
            if (!rst_n)         field_q <= '0;
            else if (cap_pulse) field_q <= live_vec[i];
        end
        assign held_vec[i] = field_q;
    end
endmodule

// File: rtl/snap_rdmux.sv
module snap_rdmux
    import snap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic [DATA_W-1:0]                 live_hund,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  held_vec,
    input  logic [DATA_W-1:0]                 ram_rdata,
    output logic [DATA_W-1:0]                 rd_data
);
    logic        ram_sel;
    time_slot_e  slot;
    logic [DATA_W-1:0] next_data;

    assign ram_sel = |rd_addr[ADDR_W-1:SLOT_W];
    assign slot    = time_slot_e'(rd_addr[SLOT_W-1:0]);

    always_comb begin
        if (ram_sel)                next_data = ram_rdata;
        else if (slot == SLOT_HUND) next_data = live_hund;
        else                        next_data = held_vec[slot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= next_data;
    end
endmodule

// File: rtl/snap_read_latch.sv
module snap_read_latch
    import snap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] cnt_hund,
    input  logic [DATA_W-1:0] cnt_hour,
    input  logic [DATA_W-1:0] cnt_min,
    input  logic [DATA_W-1:0] cnt_sec,
    input  logic [DATA_W-1:0] cnt_month,
    input  logic [DATA_W-1:0] cnt_date,
    input  logic [DATA_W-1:0] cnt_year,
    input  logic [DATA_W-1:0] cnt_wday,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_SLOTS-1:0][DATA_W-1:0] live_vec;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] held_vec;
    logic hund_hit;
    logic cap_pulse;

    // R1: slot order of the time fields
    assign live_vec[SLOT_HUND]  = cnt_hund;
    assign live_vec[SLOT_HOUR]  = cnt_hour;
    assign live_vec[SLOT_MIN]   = cnt_min;
    assign live_vec[SLOT_SEC]   = cnt_sec;
    assign live_vec[SLOT_MONTH] = cnt_month;
    assign live_vec[SLOT_DATE]  = cnt_date;
    assign live_vec[SLOT_YEAR]  = cnt_year;
    assign live_vec[SLOT_WDAY]  = cnt_wday;

    assign hund_hit = rd_en && (rd_addr == '0);

    snap_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .hund_hit  (hund_hit),
        .cap_pulse (cap_pulse)
    );

    snap_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .live_vec  (live_vec),
        .held_vec  (held_vec)
    );

    snap_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .live_hund (cnt_hund),
        .held_vec  (held_vec),
        .ram_rdata (ram_rdata),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/snap_chk.sv
module snap_chk
    import snap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              rd_en,
    input logic [ADDR_W-1:0]                 rd_addr,
    input logic [DATA_W-1:0]                 cnt_hund,
    input logic [DATA_W-1:0]                 cnt_hour,
    input logic [DATA_W-1:0]                 cnt_wday,
    input logic [DATA_W-1:0]                 ram_rdata,
    input logic [DATA_W-1:0]                 rd_data,
    input logic                              cap_pulse,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0]  held_vec
);
    // R2
    hund_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0) |=> rd_data == $past(cnt_hund));

    // R3
    cap_hour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> held_vec[SLOT_HOUR] == $past(cnt_hour));

    // R9
    cap_wday_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> held_vec[SLOT_WDAY] == $past(cnt_wday));

    // R4
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(held_vec));

    // R5
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse);

    // R7
    ram_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && |rd_addr[ADDR_W-1:SLOT_W]) |=> rd_data == $past(ram_rdata));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind snap_read_latch snap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .cnt_hund  (cnt_hund),
    .cnt_hour  (cnt_hour),
    .cnt_wday  (cnt_wday),
    .ram_rdata (ram_rdata),
    .rd_data   (rd_data),
    .cap_pulse (cap_pulse),
    .held_vec  (held_vec)
);

// File: tb/sim_snap_read_latch.sv
`timescale 1ns/1ps
module sim_snap_read_latch;
    localparam int DW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] cnt [8];
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    string tag = "R6";
    bit done = 0;

    always #2 clk = ~clk;

    snap_read_latch #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .cnt_hund(cnt[0]), .cnt_hour(cnt[1]), .cnt_min(cnt[2]), .cnt_sec(cnt[3]),
        .cnt_month(cnt[4]), .cnt_date(cnt[5]), .cnt_year(cnt[6]), .cnt_wday(cnt[7]),
        .ram_rdata(ram_rdata), .rd_data(rd_data)
    );

    // Behavioural reference model
    logic [DW-1:0] m_held [8];
    logic [DW-1:0] m_data;
    bit            m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_held[i]) m_held[i] = '0;
            m_data = '0;
            m_prev = 0;
        end else begin
            bit hit;
            hit = rd_en && (rd_addr == 0);
            if (rd_en) begin
                if (rd_addr >= 8)      m_data = ram_rdata;
                else if (rd_addr == 0) m_data = cnt[0];
                else                   m_data = m_held[rd_addr];
            end
            if (hit && !m_prev)
                for (int i = 1; i < 8; i++) m_held[i] = cnt[i];
            m_prev = hit;
        end
    end

    task automatic compare();
        vectors++;
        if (rd_data !== m_data) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h at %0t", tag, rd_data, m_data, $time);
        end
    endtask

    // Compare on every falling edge, before new stimulus
    always @(negedge clk) if (rst_n === 1'b1 && !done) compare();

    task automatic step(input bit en, input int a);
        @(negedge clk);
        rd_en   = en;
        rd_addr = AW'(a);
    endtask

    task automatic bump();
        for (int i = 0; i < 8; i++) cnt[i] = cnt[i] + DW'(i + 1);
        ram_rdata = ram_rdata + 8'h13;
    endtask

    initial begin
        logic [15:0] lfsr;
        rst_n = 0; rd_en = 0; rd_addr = '0; ram_rdata = 8'hA5;
        for (int i = 0; i < 8; i++) cnt[i] = DW'(8'h10 * i + 3);
        repeat (3) @(negedge clk);
        // R6: reset state
        vectors++;
        if (rd_data !== '0) begin
            errors++;
            $display("FAIL R6: rd_data=%02h expected=00", rd_data);
        end
        rst_n = 1;
        tag = "R6";
        for (int a = 1; a < 8; a++) step(1, a);
        tag = "R1";
        step(1, 0);
        for (int a = 1; a < 8; a++) step(1, a);
        tag = "R4";
        step(0, 0); bump();
        for (int a = 7; a >= 1; a--) step(1, a);
        tag = "R2";
        step(1, 0); step(0, 0); bump(); step(1, 0);
        tag = "R9";
        for (int k = 0; k < 3; k++) begin
            for (int a = 0; a < 8; a++) begin
                step(1, a);
                bump();
            end
        end
        tag = "R5";
        step(1, 0); bump(); step(1, 0); bump(); step(1, 0); bump(); step(1, 0);
        for (int a = 1; a < 8; a++) step(1, a);
        step(1, 0); bump(); step(0, 0); bump(); step(1, 0); bump();
        for (int a = 1; a < 8; a++) step(1, a);
        tag = "R7";
        for (int a = 8; a < 32; a++) begin
            step(1, a);
            bump();
        end
        for (int a = 1; a < 8; a++) step(1, a);
        tag = "R8";
        step(1, 3);
        for (int k = 0; k < 6; k++) begin
            step(0, k);
            bump();
        end
        tag = "R3";
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], (lfsr[5:4] == 2'b00) ? 0 : int'(lfsr[10:6]) % 12);
            if (lfsr[2]) bump();
        end
        step(0, 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule